// File: doc/BRIEF.md
# USB Clock Source Selector with PLL Lock Timer

This block chooses which clock pulses drive the USB function and reports whether the USB PLL is treated as locked. All clock sources reach it as one-cycle tick enables on a single fast reference clock: a 48 MHz primary-oscillator tick, a 96 MHz PLL tick and a slow internal RC tick. The block produces one clock enable, `clk_en`, for the USB function logic.

In normal running, the 48 MHz enable comes in one of two ways. It is either the primary-oscillator tick passed straight through, or every second PLL tick, which halves the 96 MHz rate. While the USB core reports suspend, the block passes only the RC tick. That keeps bus-activity detection alive without either 48 MHz source. Activity arrives from the RC domain through a synchronizer and raises a resume request. The switch back to 48 MHz waits until the chosen source is ready.

The lock flag is a timeout and does not measure the PLL. It counts a fixed number of cycles while the PLL is enabled and selected, and it clears as soon as either condition drops. The oscillators and the analog PLL, including its 4 MHz input prescaler, are outside this block.

Top module: `usbclk_sel`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pll_locked` and `resume_req` are 0, the block is in the running state, and the divide-by-two phase is cleared.
- R2: In the running state with `src_sel` = 0 (primary oscillator), `clk_en` equals `posc_tick` in the same cycle.
- R3: In the running state with `src_sel` = 1 (PLL) and `pll_locked` = 1, `clk_en` is high only on PLL ticks whose phase is odd. The phase toggles at every clock edge that samples `pll_tick` high, so the pass goes to the 2nd, 4th, 6th, ... PLL tick since reset.
- R4: `pll_locked` rises at the LOCK_CYCLES-th consecutive clock edge that samples both `pll_en` and `src_sel` high. It then stays high while both remain high.
- R5: At any edge that samples `pll_en` = 0 or `src_sel` = 0, `pll_locked` clears and the count restarts from zero.
- R6: With `src_sel` = 0, `pll_locked` stays 0 whatever `pll_en` does.
- R7: In the running state with `src_sel` = 1 and `pll_locked` = 0, `clk_en` is 0.
- R8: An edge that samples `suspend` = 1 in the running state moves the block to suspend. Outside the running state, `clk_en` equals `frc_tick`, and the 48 MHz ticks have no effect on it.
- R9: In suspend, `activity` first sampled high at edge n (with SYNC_STAGES = 2) sets `resume_req` at edge n+2 and moves the block to the waking state.
- R10: In the waking state, the block returns to running, and `resume_req` clears, at the first edge that samples `suspend` = 0 with the source ready. The source is ready when `src_sel` = 0, or when `pll_locked` = 1. Until then `clk_en` keeps following `frc_tick`.
- R11: When `suspend` drops in the suspend state with no synchronized activity, the block moves to waking without raising `resume_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | 48 MHz source choice: 0 primary oscillator, 1 PLL halved |
| pll_en | input | 1 | USB PLL enable |
| suspend | input | 1 | USB core is in suspend |
| activity | input | 1 | Bus activity flag from the RC domain (asynchronous) |
| posc_tick | input | 1 | 48 MHz primary-oscillator tick |
| pll_tick | input | 1 | 96 MHz PLL tick |
| frc_tick | input | 1 | Internal RC oscillator tick |
| clk_en | output | 1 | Selected USB clock enable |
| pll_locked | output | 1 | Timed PLL lock flag |
| resume_req | output | 1 | Request to leave suspend after activity |

## Verification
The bench targets lock-count boundaries:
- A timer that is off by one raises `pll_locked` one edge early or late.
- Dropping the enable for a single cycle must restart the full count. A timer that only pauses would relock too soon.

It also targets the wake path:
- Activity while the PLL is unlocked must hold the block on the RC tick.
- A design that switched on `suspend` alone would emit a gated-off or early 48 MHz stream.

The divider phase is checked across irregular PLL tick patterns. A phase that counted reference cycles instead of PLL ticks would pass odd-numbered ticks.

The bench also leaves suspend without activity, where a careless design would raise a false resume request.

// File: rtl/usbclk_pkg.sv
// Shared types for the USB clock source selector.
package usbclk_pkg;

    // Operating state of the wake controller.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } wake_state_e;

endpackage

// File: rtl/usbclk_lock_timer.sv
// Lock timer: raises 'locked' once 'arm' has been sampled high for
// LOCK_CYCLES consecutive edges. Any edge with 'arm' low clears it.
// Assumes the PLL settles within LOCK_CYCLES; it never observes the PLL.
module usbclk_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 2000,
    parameter int unsigned CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic locked
);

    logic [CNT_W-1:0] cnt_q;

    // Count armed edges; saturate into the lock flag, restart when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end else if (!arm) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end else if (!locked) begin
            if (cnt_q == CNT_W'(LOCK_CYCLES - 1)) begin
                locked <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_disarm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !locked);

    assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && arm) |=> locked);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LOCK_CYCLES));

endmodule

// File: rtl/usbclk_wake_fsm.sv
// Wake controller: synchronizes RC-domain activity and steps through
// run, sleep and wake. It raises a resume request on activity during
// sleep and returns to run only once the 48 MHz source is ready.
// Assumes 'activity' is held for at least SYNC_STAGES clock cycles.
module usbclk_wake_fsm
    import usbclk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        suspend,
    input  logic        activity,
    input  logic        src_ready,
    output wake_state_e state,
    output logic        resume_req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   act_seen;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            // Single-flop capture of the asynchronous activity flag.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= activity;
            end
        end else begin : g_sync_chain
            // Shift the asynchronous activity flag through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], activity};
            end
        end
    endgenerate

    assign act_seen = sync_q[SYNC_STAGES-1];

    // State transitions and resume request bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            resume_req <= 1'b0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (suspend) state <= ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (act_seen) begin
                        state      <= ST_WAKE;
                        resume_req <= 1'b1;
                    end else if (!suspend) begin
                        state <= ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (!suspend && src_ready) begin
                        state      <= ST_RUN;
                        resume_req <= 1'b0;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assert_req_from_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_req) |-> $past(state) == ST_SLEEP);

    assert_req_waits_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_req && !src_ready) |=> resume_req);

    assert_quiet_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !act_seen && !suspend) |=> !resume_req);

endmodule

// File: rtl/usbclk_src_mux.sv
// Source multiplexer: halves the PLL tick stream with a phase flop and
// picks the tick that reaches the USB function. It uses the RC tick
// outside the running state and gates the PLL path until lock.
// Assumes every tick input lasts exactly one reference cycle.
module usbclk_src_mux
    import usbclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  wake_state_e state,
    input  logic        src_sel,
    input  logic        locked,
    input  logic        posc_tick,
    input  logic        pll_tick,
    input  logic        frc_tick,
    output logic        clk_en
);

    logic phase_q;
    logic pll_half;

    // Toggle the divide-by-two phase on every PLL tick.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_q ^ pll_tick;
    end

    assign pll_half = pll_tick & phase_q;

    // Choose the outgoing tick from state, source and lock.
    always_comb begin
        if (state != ST_RUN) clk_en = frc_tick;
        else if (src_sel)    clk_en = pll_half & locked;
        else                 clk_en = posc_tick;
    end

    assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && state == ST_RUN && src_sel) |=> !(clk_en && state == ST_RUN && src_sel));

endmodule

// File: rtl/usbclk_sel.sv
// USB clock source selector top: ties the lock timer, wake controller
// and source multiplexer together. The timer is armed only while the
// PLL is both enabled and selected. Assumes one reference clock with
// all sources presented as tick enables.
module usbclk_sel
    import usbclk_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 2000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic pll_en,
    input  logic suspend,
    input  logic activity,
    input  logic posc_tick,
    input  logic pll_tick,
    input  logic frc_tick,
    output logic clk_en,
    output logic pll_locked,
    output logic resume_req
);

    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);

    wake_state_e state;
    logic        arm;
    logic        src_ready;

    assign arm       = pll_en & src_sel;
    assign src_ready = ~src_sel | pll_locked;

    usbclk_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .CNT_W       (CNT_W)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .locked (pll_locked)
    );

    usbclk_wake_fsm #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .suspend    (suspend),
        .activity   (activity),
        .src_ready  (src_ready),
        .state      (state),
        .resume_req (resume_req)
    );

    usbclk_src_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .src_sel   (src_sel),
        .locked    (pll_locked),
        .posc_tick (posc_tick),
        .pll_tick  (pll_tick),
        .frc_tick  (frc_tick),
        .clk_en    (clk_en)
    );

    assert_unlocked_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && src_sel && !pll_locked) |-> !clk_en);

    assert_no_lock_on_posc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !src_sel |=> !pll_locked);

endmodule

// File: tb/usbclk_sel_test.sv
// Self-checking bench: drives mode sweeps and scripted suspend/resume
// scenarios, and predicts every output from the written requirements.
module usbclk_sel_test;

    localparam int CLK_PERIOD = 10;
    localparam int LOCKN      = 20;

    logic clk = 1'b0;
    logic rst_n, src_sel, pll_en, suspend, activity;
    logic posc_tick, pll_tick, frc_tick;
    logic clk_en, pll_locked, resume_req;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    // Prediction state: 0 run, 1 sleep, 2 wake.
    int  m_state = 0;
    bit  m_req = 0;
    bit  m_a1 = 0, m_a2 = 0;
    bit  m_par = 0;
    int  m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbclk_sel #(.LOCK_CYCLES(LOCKN), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pll_en(pll_en),
        .suspend(suspend), .activity(activity), .posc_tick(posc_tick),
        .pll_tick(pll_tick), .frc_tick(frc_tick), .clk_en(clk_en),
        .pll_locked(pll_locked), .resume_req(resume_req)
    );

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
        end
    endtask

    // One cycle: drive inputs, check outputs, take the edge, advance the prediction.
    task automatic step(input bit sel, input bit en, input bit sp, input bit act);
        bit    m_lock, e_clk, ready;
        string tclk, tlock, treq;
        src_sel   = sel; pll_en = en; suspend = sp; activity = act;
        posc_tick = (cyc % 2) == 0;
        pll_tick  = (cyc % 3) != 0;
        frc_tick  = (cyc % 7) == 0;
        #1;
        m_lock = (m_cnt >= LOCKN);
        if (m_state != 0)  begin e_clk = frc_tick;                      tclk = "R8"; end
        else if (sel)      begin e_clk = m_lock & pll_tick & m_par;     tclk = m_lock ? "R3" : "R7"; end
        else               begin e_clk = posc_tick;                     tclk = "R2"; end
        tlock = !sel ? "R6" : (!en ? "R5" : "R4");
        treq  = (m_state == 2) ? (m_req ? "R10" : "R11") : "R9";
        check(tclk,  "clk_en",     clk_en,     e_clk);
        check(tlock, "pll_locked", pll_locked, m_lock);
        check(treq,  "resume_req", resume_req, m_req);
        @(posedge clk);
        ready = !sel || m_lock;
        case (m_state)
            0: if (sp) m_state = 1;
            1: if (m_a2) begin m_state = 2; m_req = 1; end
               else if (!sp) m_state = 2;
            default: if (!sp && ready) begin m_state = 0; m_req = 0; end
        endcase
        m_a2  = m_a1;
        m_a1  = act;
        m_par = m_par ^ pll_tick;
        m_cnt = (sel && en) ? ((m_cnt < LOCKN) ? m_cnt + 1 : m_cnt) : 0;
        cyc++;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_sel = 1'b1; pll_en = 1'b1; suspend = 1'b0; activity = 1'b1;
        posc_tick = 1'b0; pll_tick = 1'b1; frc_tick = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, even with PLL armed and activity high
        check("R1", "pll_locked", pll_locked, 1'b0);
        check("R1", "resume_req", resume_req, 1'b0);
        check("R1", "clk_en",     clk_en,     1'b0);
        activity = 1'b0;
        rst_n = 1'b1;

        repeat (24) step(0, 0, 0, 0);                 // R2 direct path
        repeat (12) step(1, 0, 0, 0);                 // R7 unlocked PLL gated
        repeat (30) step(0, 1, 0, 0);                 // R6 no lock on primary
        repeat (40) step(1, 1, 0, 0);                 // R4 lock, R3 halving
        step(1, 0, 0, 0);                             // R5 one-cycle drop
        repeat (30) step(1, 1, 0, 0);                 // R4 full recount
        step(0, 1, 0, 0);                             // R5 deselect drop
        repeat (25) step(1, 1, 0, 0);
        repeat (15) step(1, 1, 1, 0);                 // R8 suspend on RC tick
        step(1, 0, 1, 1);                             // R9 activity, PLL off
        repeat (6) step(1, 0, 1, 0);
        repeat (5) step(1, 0, 0, 0);                  // R10 wait, no lock
        repeat (30) step(1, 1, 0, 0);                 // R10 relock then run
        repeat (10) step(0, 0, 1, 0);                 // R11 quiet exit
        repeat (6) step(0, 0, 0, 0);

        // Sweep every select/enable/suspend combination, both orders.
        for (int m = 0; m < 8; m++)
            for (int k = 0; k < 24; k++)
                step(m[0], m[1], m[2], (k == 7) && m[2]);
        for (int m = 7; m >= 0; m--)
            for (int k = 0; k < 24; k++)
                step(m[0], m[1], m[2], (k == 3) && m[2]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule